// File: doc/BRIEF.md
# Single-Cycle Six-Instruction RISC Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It holds its own program counter, a word-organised instruction store, a word-organised data store and a 32-entry register file with two read ports and one write port. A sign extender feeds both the ALU and a dedicated branch-target adder.

The decoder recognises six operations: add, subtract, load of a 16-bit constant into the low half of a register, word load, word store and branch-if-equal. A branch is relative to the already-incremented PC, and its offset counts whole words.

Both stores are filled through a preload port, normally while reset is held. Execution starts from byte address 0 once reset drops. The core has no streaming data interface, so every pin is a plain control or status signal without handshake or back-pressure. A testbench watches progress through the PC output, the register-write strobe with its index and value, and the store strobe with its address and data.

Top module: `sc_core`

## Requirements
- R1: `rst` is synchronous and active high. While it is high, at every rising edge the PC becomes 0, and `rf_we_o` and `dm_we_o` stay low.
- R2: Fields are opcode = instr[31:26], rs = [25:21], rt = [20:16], rd = [15:11] and funct = [5:0]. Opcode 0 with funct 6'h20 writes rs + rt into rd. Both sources are read before the write, so an instruction may name the same register as a source and as the destination.
- R3: Opcode 0 with funct 6'h22 writes rs - rt (modulo 2^32) into rd.
- R4: Opcode 13 writes {16'h0000, instr[15:0]} into rt.
- R5: Opcode 35 writes into rt the data word at byte address rs + sign-extended instr[15:0]. The word index is that address shifted right by 2.
- R6: Opcode 43 stores rt at byte address rs + sign-extended instr[15:0]. In that cycle `dm_we_o` is high with that address and data, and no register is written.
- R7: Opcode 4 with rs equal to rt sets the next PC to PC + 4 + (sign-extended instr[15:0] << 2).
- R8: Opcode 4 with rs not equal to rt, and every other instruction, sets the next PC to PC + 4.
- R9: Register 0 always reads as zero. A write aimed at register 0 is dropped, and `rf_we_o` stays low for it.
- R10: An opcode outside {0, 4, 13, 35, 43}, or opcode 0 with a funct other than 6'h20 or 6'h22, writes nothing and only advances the PC.
- R11: While `pre_we` is high, `pre_data` is written at word index `pre_addr`. The target is the instruction store when `pre_sel` is 0 and the data store when `pre_sel` is 1. Indices beyond a store's depth are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Preload write enable |
| pre_sel | input | 1 | Preload target: 0 instruction store, 1 data store |
| pre_addr | input | 32 | Preload word index |
| pre_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter (byte address) |
| rf_we_o | output | 1 | Register write strobe for the current instruction |
| rf_waddr_o | output | 5 | Register index being written |
| rf_wdata_o | output | 32 | Value being written |
| dm_we_o | output | 1 | Data store write strobe |
| dm_addr_o | output | 32 | Data store byte address |
| dm_wdata_o | output | 32 | Data store write word |

## Verification
Two things coincide in a single clock: register reads for an instruction and the write-back of that same instruction to one of its own source registers. The test provokes this with an add that doubles R1 into R1. It judges the result by requiring the strobe to carry exactly twice the earlier value, and by requiring a later store and reload to return that doubled value. A branch and its comparison also share one cycle. The program runs a taken compare whose skipped instruction must never produce a write strobe, and a not-taken compare, with the expected PC tracked every cycle.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int REG_AW = 5;

  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_LLI  = 6'd13;
  localparam logic [5:0] OP_LW   = 6'd35;
  localparam logic [5:0] OP_SW   = 6'd43;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;

  typedef struct packed {
    logic reg_we;
    logic dst_rd;
    logic alu_sub;
    logic use_imm;
    logic mem_rd;
    logic mem_we;
    logic branch;
    logic lli;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (op)
      OP_REG: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctrl.reg_we  = 1'b1;
          ctrl.dst_rd  = 1'b1;
          ctrl.alu_sub = (funct == FN_SUB);
        end
      end
      OP_LLI: begin
        ctrl.reg_we = 1'b1;
        ctrl.lli    = 1'b1;
      end
      OP_LW: begin
        ctrl.reg_we  = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_SW: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.alu_sub = 1'b1;
        ctrl.branch  = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            sub,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  logic [XLEN-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    y     = a + b_eff + {{(XLEN-1){1'b0}}, sub};
    zero  = (y == '0);
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN   = 32,
  parameter int NREGS  = 32,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic [AW-1:0]   ra,
  input  logic [AW-1:0]   rb,
  output logic [XLEN-1:0] da,
  output logic [XLEN-1:0] db,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign da = (ra == '0) ? '0 : regs[ra];
  assign db = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_we,
  input  logic              pre_sel,
  input  logic [XLEN-1:0]   pre_addr,
  input  logic [XLEN-1:0]   pre_data,
  output logic [XLEN-1:0]   pc_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              dm_we_o,
  output logic [XLEN-1:0]   dm_addr_o,
  output logic [XLEN-1:0]   dm_wdata_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc, pc_plus4, br_tgt, instr, sext;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_data;
  logic [XLEN-3:0] pc_word, dm_word;
  logic            alu_zero, i_in, d_in, take;
  logic [REG_AW-1:0] waddr;
  ctrl_t           ctrl;
  logic            unused_shamt;

  // fetch
  assign pc_word = pc[XLEN-1:2];
  assign i_in    = (pc_word < (XLEN-2)'(IMEM_WORDS));
  assign instr   = i_in ? imem[pc_word[IAW-1:0]] : '0;
  assign unused_shamt = ^instr[10:6];

  always_ff @(posedge clk) begin
    if (pre_we && !pre_sel && pre_addr < XLEN'(IMEM_WORDS))
      imem[pre_addr[IAW-1:0]] <= pre_data;
  end

  sc_decode u_dec (
    .op    (instr[31:26]),
    .funct (instr[5:0]),
    .ctrl  (ctrl)
  );

  sc_regfile #(.XLEN(XLEN), .NREGS(1 << REG_AW)) u_rf (
    .clk (clk),
    .ra  (instr[25:21]),
    .rb  (instr[20:16]),
    .da  (rs_val),
    .db  (rt_val),
    .we  (rf_we_o),
    .wa  (waddr),
    .wd  (wb_data)
  );

  assign sext  = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b = ctrl.use_imm ? sext : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .sub  (ctrl.alu_sub),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data store: preload wins over a core store in the same cycle
  assign dm_word  = alu_y[XLEN-1:2];
  assign d_in     = (dm_word < (XLEN-2)'(DMEM_WORDS));
  assign dm_rdata = d_in ? dmem[dm_word[DAW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (pre_we && pre_sel) begin
      if (pre_addr < XLEN'(DMEM_WORDS)) dmem[pre_addr[DAW-1:0]] <= pre_data;
    end else if (dm_we_o && d_in) begin
      dmem[dm_word[DAW-1:0]] <= rt_val;
    end
  end

  // write-back
  assign waddr   = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign wb_data = ctrl.lli    ? {{(XLEN-16){1'b0}}, instr[15:0]} :
                   ctrl.mem_rd ? dm_rdata : alu_y;

  // next PC
  assign pc_plus4 = pc + XLEN'(4);
  assign br_tgt   = pc_plus4 + {sext[XLEN-3:0], 2'b00};
  assign take     = ctrl.branch & alu_zero;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= take ? br_tgt : pc_plus4;
  end

  assign pc_o       = pc;
  assign rf_we_o    = ctrl.reg_we & ~rst & (waddr != '0);
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = ctrl.mem_we & ~rst;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc,
  input logic            rf_we,
  input logic [4:0]      rf_waddr,
  input logic [XLEN-1:0] rf_wdata,
  input logic            dm_we,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val
);
  logic [5:0] op;
  logic       known;
  assign op    = instr[31:26];
  assign known = (op == 6'd4) || (op == 6'd13) || (op == 6'd35) || (op == 6'd43) ||
                 (op == 6'd0 && (instr[5:0] == 6'h20 || instr[5:0] == 6'h22));

  a_r1_reset_pc: assert property (@(posedge clk) $past(rst) |-> pc == '0);

  a_r9_no_r0_strobe: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> rf_waddr != 5'd0);

  a_r6_store_no_rf: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> !rf_we);

  a_r4_lli_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd13 && instr[20:16] != 5'd0) |-> (rf_we && rf_wdata[XLEN-1:16] == '0));

  a_r10_undef_nop: assert property (@(posedge clk) disable iff (rst)
    !known |-> (!rf_we && !dm_we));

  a_r8_seq_pc: assert property (@(posedge clk) disable iff (rst)
    (op != 6'd4 || rs_val != rt_val) |=> pc == $past(pc) + XLEN'(4));

  a_r7_beq_taken: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd4 && rs_val == rt_val) |=>
      pc == $past(pc) + XLEN'(4) + {{(XLEN-18){$past(instr[15])}}, $past(instr[15:0]), 2'b00});
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_o),
  .rf_we    (rf_we_o),
  .rf_waddr (rf_waddr_o),
  .rf_wdata (rf_wdata_o),
  .dm_we    (dm_we_o),
  .instr    (instr),
  .rs_val   (rs_val),
  .rt_val   (rt_val)
);

// File: tb/test_sc_core.sv
module test_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pre_we = 1'b0;
  logic        pre_sel = 1'b0;
  logic [31:0] pre_addr = '0;
  logic [31:0] pre_data = '0;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sc_core i_sc_core (
    .clk(clk), .rst(rst), .pre_we(pre_we), .pre_sel(pre_sel),
    .pre_addr(pre_addr), .pre_data(pre_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  typedef struct {
    bit          is_mem;
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } item_t;

  item_t       exp_q[$];
  logic [31:0] pc_q[$];

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload(input bit sel, input int idx, input logic [31:0] w);
    @(negedge clk);
    pre_we = 1'b1; pre_sel = sel; pre_addr = 32'(idx); pre_data = w;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic exp_rf(input int a, input logic [31:0] d, input string req);
    item_t it;
    it.is_mem = 1'b0; it.addr = 32'(a); it.data = d; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic exp_dm(input logic [31:0] a, input logic [31:0] d, input string req);
    item_t it;
    it.is_mem = 1'b1; it.addr = a; it.data = d; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic monitor_cycle();
    item_t it;
    logic [31:0] ep;
    ep = pc_q.pop_front();
    check(pc_o == ep, "R7/R8 pc", pc_o, ep);
    if (rf_we_o) begin
      if (exp_q.size() == 0 || exp_q[0].is_mem) begin
        check(1'b0, "R9/R10 unexpected reg write", {27'd0, rf_waddr_o}, rf_wdata_o);
      end else begin
        it = exp_q.pop_front();
        check(rf_waddr_o == it.addr[4:0], it.req, {27'd0, rf_waddr_o}, it.addr);
        check(rf_wdata_o == it.data, it.req, rf_wdata_o, it.data);
      end
    end
    if (dm_we_o) begin
      if (exp_q.size() == 0 || !exp_q[0].is_mem) begin
        check(1'b0, "R6 unexpected store", dm_addr_o, dm_wdata_o);
      end else begin
        it = exp_q.pop_front();
        check(dm_addr_o == it.addr, it.req, dm_addr_o, it.addr);
        check(dm_wdata_o == it.data, it.req, dm_wdata_o, it.data);
      end
    end
  endtask

  initial begin
    logic [31:0] prog [16];
    prog[0]  = enc_i(6'd13, 0, 1, 16'd10);
    prog[1]  = enc_r(1, 1, 1, 6'h20);
    prog[2]  = enc_i(6'd13, 0, 2, 16'd16);
    prog[3]  = enc_i(6'd43, 2, 1, 16'hFFFC);
    prog[4]  = enc_i(6'd35, 2, 3, 16'hFFFC);
    prog[5]  = enc_r(3, 1, 4, 6'h22);
    prog[6]  = enc_i(6'd4, 3, 1, 16'd1);
    prog[7]  = enc_i(6'd13, 0, 5, 16'hDEAD);
    prog[8]  = enc_i(6'd4, 1, 2, 16'd5);
    prog[9]  = enc_r(1, 1, 0, 6'h20);
    prog[10] = enc_r(0, 1, 6, 6'h20);
    prog[11] = {6'h3F, 5'd1, 5'd9, 16'h0005};
    prog[12] = enc_r(1, 1, 10, 6'h25);
    prog[13] = enc_i(6'd35, 0, 7, 16'd0);
    prog[14] = enc_r(0, 1, 8, 6'h22);
    prog[15] = enc_i(6'd4, 0, 0, 16'hFFFF);

    repeat (2) @(negedge clk);
    #2;
    check(pc_o == 32'd0, "R1 reset pc", pc_o, 32'd0);
    check(!rf_we_o && !dm_we_o, "R1 strobes low", {30'd0, rf_we_o, dm_we_o}, 32'd0);

    for (int i = 0; i < 16; i++) preload(1'b0, i, prog[i]);
    preload(1'b1, 0, 32'h1234_5678);
    preload(1'b1, 3, 32'h0000_AAAA);

    exp_rf(1, 32'd10, "R4 lli");
    exp_rf(1, 32'd20, "R2 add same-reg");
    exp_rf(2, 32'd16, "R4 lli");
    exp_dm(32'd12, 32'd20, "R6 store negative offset");
    exp_rf(3, 32'd20, "R5 load back");
    exp_rf(4, 32'd0, "R3 sub zero");
    exp_rf(6, 32'd20, "R9 r0 reads zero");
    exp_rf(7, 32'h1234_5678, "R11 R5 preloaded word");
    exp_rf(8, 32'hFFFF_FFEC, "R3 sub negative");

    foreach (prog[i]) begin
      if (i < 7) pc_q.push_back(32'(i * 4));
      else if (i > 7) pc_q.push_back(32'(i * 4));
    end
    for (int i = 0; i < 5; i++) pc_q.push_back(32'd60);

    @(negedge clk);
    check(pc_o == 32'd0, "R1 pc held in reset", pc_o, 32'd0);
    rst = 1'b0;
    while (pc_q.size() > 0) begin
      #2;
      monitor_cycle();
      @(negedge clk);
    end
    check(exp_q.size() == 0, "R10 all expected writes seen", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", pc_o, 32'd60);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule